// File: doc/BRIEF.md
# Quad-Channel Serial DAC Register Front End

This block is the digital side of a four-channel, 8-bit voltage DAC. A host shifts 12-bit command words into it over a three-wire serial link: clock, data and an active-low select, with the data sampled on the clock's rising edge (clock idle low). When the select line returns high after exactly twelve clock pulses, the word is decoded. Each channel has two 8-bit registers. An input register is written by commands. A DAC register drives the converter, and the block exposes its value on `dac_word`. Commands can write one input register, write one and then refresh all DAC registers, refresh all DAC registers, or pick the edge on which the serial output moves.

Two active-low control inputs act outside the serial protocol. The update input copies every input register into its DAC register. The clear input zeroes both banks and overrides everything else. The serial output presents the most significant bit of the 12-bit shift register. A host can therefore read back the previous word, or chain several devices on one select line. All serial and control pins pass through two-flop synchronizers into the system clock domain. The system clock must run at least six times faster than the serial clock.

The frame tracker is a four-state machine. FR_IDLE waits with select high and goes to FR_ACTIVE when select falls. FR_ACTIVE counts rising edges and moves to FR_FULL on the twelfth. FR_FULL goes to FR_OVER on any further rising edge. In FR_FULL, a rise of select issues the command strobe and returns to FR_IDLE. From FR_ACTIVE or FR_OVER, a rise of select returns to FR_IDLE with no strobe.

Top module: `qdac_serial_front`

## Requirements
- R1: After reset every DAC value is zero, every input register is zero, the serial output is 0 and the output-edge mode is rising.
- R2: A word is 12 bits sent MSB first, sampled on serial-clock rising edges while select is low: bits [11:10] channel, bits [9:8] operation, bits [7:0] data.
- R3: Operation 00 writes the data to the selected channel's input register and leaves every DAC value unchanged.
- R4: Operation 01 writes the selected input register and, in the same step, copies all four input registers (including the new value) into the DAC registers.
- R5: Operation 10 copies all four input registers into the DAC registers; its channel and data fields are ignored.
- R6: Operation 11 copies all input registers into the DAC registers and sets the output-edge mode from data bit 0 (1 = falling edge, 0 = rising edge).
- R7: A frame whose select rises after any rising-edge count other than 12 changes no input register, DAC register or mode.
- R8: While the update input is low, every DAC register takes its input register's value.
- R9: While the clear input is low, all input and DAC registers are zero; the clear overrides the update input and any command decoded meanwhile.
- R10: In rising mode, after each serial-clock rising edge the serial output equals the new MSB of the shift register, so it replays the preceding 12 shifted bits in order.
- R11: In falling mode, the serial output takes the shift register's MSB at each serial-clock falling edge and holds through the rising edge.
- R12: DAC values change only after a decoded command, the update input or the clear input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ser_clk | input | 1 | Serial clock, idle low |
| ser_din | input | 1 | Serial data in |
| ser_cs_n | input | 1 | Active-low frame select |
| upd_all_n | input | 1 | Active-low copy of all input registers to DAC registers |
| clr_all_n | input | 1 | Active-low clear of both register banks |
| ser_dout | output | 1 | Serial data out for read-back and chaining |
| dac_word | output | 32 | DAC register values, channel n in bits [8n+7:8n] |

## Verification
The hardest situation to observe is a command that arrives while the clear input is held low. Its effect must be absent from both banks and from the mode. The input registers are not visible at the ports, so the bench sends the command under clear, releases clear, and then issues an update-all word; the DAC values then expose the input bank. The same read-back step covers malformed frames of 8 to 15 bits, which the random stimulus mixes among valid words. Serial-output timing is checked in both edge modes, in the high and low phase of every bit.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        OP_LOAD_IN  = 2'b00,
        OP_LOAD_UPD = 2'b01,
        OP_UPD_ALL  = 2'b10,
        OP_SET_MODE = 2'b11
    } qdac_op_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_ACTIVE,
        FR_FULL,
        FR_OVER
    } frame_state_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d};
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import qdac_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              csn_s,
    input  logic              fall_mode,
    output logic              frame_stb,
    output logic [WORD_W-1:0] frame_word,
    output logic              dout,
    output logic              sclk_rise,
    output logic              sclk_fall
);

    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(WORD_W - 1);

    frame_state_e state_q, state_nx;
    logic         sclk_d;
    logic [CW-1:0] cnt_q;
    logic [WORD_W-1:0] sr_q;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FR_IDLE: begin
                if (!csn_s) state_nx = FR_ACTIVE;
            end
            FR_ACTIVE: begin
                if (csn_s)                              state_nx = FR_IDLE;
                else if (sclk_rise && cnt_q == LAST_CNT) state_nx = FR_FULL;
            end
            FR_FULL: begin
                if (csn_s)          state_nx = FR_IDLE;
                else if (sclk_rise) state_nx = FR_OVER;
            end
            FR_OVER: begin
                if (csn_s) state_nx = FR_IDLE;
            end
            default: state_nx = FR_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d    <= 1'b0;
            cnt_q     <= '0;
            sr_q      <= '0;
            dout      <= 1'b0;
            frame_stb <= 1'b0;
        end else begin
            sclk_d    <= sclk_s;
            frame_stb <= (state_q == FR_FULL) && csn_s;
            if (csn_s) begin
                cnt_q <= '0;
            end else begin
                if (sclk_rise) begin
                    sr_q <= {sr_q[WORD_W-2:0], din_s};
                    if (cnt_q != LAST_CNT + 1'b1) cnt_q <= cnt_q + 1'b1;
                    if (!fall_mode) dout <= sr_q[WORD_W-2];
                end
                if (sclk_fall && fall_mode) dout <= sr_q[WORD_W-1];
            end
        end
    end

    assign frame_word = sr_q;

endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
    import qdac_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 8,
    parameter int CHW    = 2,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [WORD_W-1:0] frame_word,
    input  logic              ldn_s,
    input  logic              clrn_s,
    output logic [NCH*DW-1:0] inp_word,
    output logic [NCH*DW-1:0] dac_word,
    output logic              fall_mode
);

    qdac_op_e       op;
    logic [CHW-1:0] sel;
    logic [DW-1:0]  data;
    logic           wr_in, upd_load, upd_copy, set_mode;

    assign sel  = frame_word[WORD_W-1 -: CHW];
    assign op   = qdac_op_e'(frame_word[DW +: 2]);
    assign data = frame_word[DW-1:0];

    always_comb begin
        wr_in    = 1'b0;
        upd_load = 1'b0;
        upd_copy = 1'b0;
        set_mode = 1'b0;
        if (frame_stb) begin
            unique case (op)
                OP_LOAD_IN:  wr_in = 1'b1;
                OP_LOAD_UPD: begin wr_in = 1'b1; upd_load = 1'b1; end
                OP_UPD_ALL:  upd_copy = 1'b1;
                OP_SET_MODE: begin upd_copy = 1'b1; set_mode = 1'b1; end
                default: ;
            endcase
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [DW-1:0] inp_q, dac_q;
        logic          hit;
        assign hit = (sel == CHW'(ch));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                inp_q <= '0;
                dac_q <= '0;
            end else if (!clrn_s) begin
                inp_q <= '0;
                dac_q <= '0;
            end else begin
                if (wr_in && hit) inp_q <= data;
                if (upd_load)      dac_q <= hit ? data : inp_q;
                else if (upd_copy) dac_q <= inp_q;
                else if (!ldn_s)   dac_q <= inp_q;
            end
        end

        assign inp_word[ch*DW +: DW] = inp_q;
        assign dac_word[ch*DW +: DW] = dac_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_mode <= 1'b0;
        end else if (clrn_s && set_mode) begin
            fall_mode <= data[0];
        end
    end

endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
    import qdac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_cs_n,
    input  logic              upd_all_n,
    input  logic              clr_all_n,
    output logic              ser_dout,
    output logic [NCH*DW-1:0] dac_word
);

    localparam int CHW    = $clog2(NCH);
    localparam int WORD_W = CHW + 2 + DW;

    logic [4:0]        sync_in, sync_out;
    logic              sclk_s, din_s, csn_s, ldn_s, clrn_s;
    logic              frame_stb, fall_mode, sclk_rise, sclk_fall;
    logic [WORD_W-1:0] frame_word;
    logic [NCH*DW-1:0] inp_word;

    assign sync_in = {ser_clk, ser_din, ser_cs_n, upd_all_n, clr_all_n};
    assign {sclk_s, din_s, csn_s, ldn_s, clrn_s} = sync_out;

    qdac_sync #(
        .W       (5),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b00111)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    qdac_frame_rx #(
        .WORD_W (WORD_W)
    ) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .din_s      (din_s),
        .csn_s      (csn_s),
        .fall_mode  (fall_mode),
        .frame_stb  (frame_stb),
        .frame_word (frame_word),
        .dout       (ser_dout),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall)
    );

    qdac_regs #(
        .NCH    (NCH),
        .DW     (DW),
        .CHW    (CHW),
        .WORD_W (WORD_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .frame_word (frame_word),
        .ldn_s      (ldn_s),
        .clrn_s     (clrn_s),
        .inp_word   (inp_word),
        .dac_word   (dac_word),
        .fall_mode  (fall_mode)
    );

endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_stb,
    input logic              ldn_s,
    input logic              clrn_s,
    input logic [NCH*DW-1:0] inp_word,
    input logic [NCH*DW-1:0] dac_word,
    input logic              dout,
    input logic              fall_mode,
    input logic              sclk_rise,
    input logic              sclk_fall
);

    assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clrn_s |=> (dac_word == '0 && inp_word == '0));

    assert_update_copies_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldn_s && clrn_s && !frame_stb) |=> (dac_word == $past(inp_word)));

    assert_dac_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_word) |-> $past(frame_stb || !ldn_s || !clrn_s));

    // input bank moves only on a decoded frame or a clear (R7)
    assert_input_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(inp_word) |-> $past(frame_stb || !clrn_s));

    // serial output moves only on the edge its mode selects (R10, R11)
    assert_dout_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(fall_mode ? sclk_fall : sclk_rise));

endmodule

bind qdac_serial_front qdac_front_chk #(
    .NCH (NCH),
    .DW  (DW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .ldn_s     (ldn_s),
    .clrn_s    (clrn_s),
    .inp_word  (inp_word),
    .dac_word  (dac_word),
    .dout      (ser_dout),
    .fall_mode (fall_mode),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
);

// File: tb/qdac_serial_front_tb_top.sv
module qdac_serial_front_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PH         = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_cs_n = 1'b1;
    logic        upd_all_n = 1'b1;
    logic        clr_all_n = 1'b1;
    logic        ser_dout;
    logic [31:0] dac_word;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [7:0]  m_inp [4];
    logic [7:0]  m_dac [4];
    logic        m_fall;
    logic [11:0] m_sr;
    bit          m_clr;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_serial_front dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_din   (ser_din),
        .ser_cs_n  (ser_cs_n),
        .upd_all_n (upd_all_n),
        .clr_all_n (clr_all_n),
        .ser_dout  (ser_dout),
        .dac_word  (dac_word)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_dacs();
        return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
    endfunction

    function automatic string op_tag(input logic [11:0] w);
        case (w[9:8])
            2'b00:   return "R2 R3 R12";
            2'b01:   return "R2 R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply_word(input logic [11:0] w);
        int sel;
        sel = int'(w[11:10]);
        if (m_clr) return;
        case (w[9:8])
            2'b00: m_inp[sel] = w[7:0];
            2'b01: begin
                m_inp[sel] = w[7:0];
                for (int i = 0; i < 4; i++) m_dac[i] = m_inp[i];
            end
            2'b10: for (int i = 0; i < 4; i++) m_dac[i] = m_inp[i];
            default: begin
                for (int i = 0; i < 4; i++) m_dac[i] = m_inp[i];
                m_fall = w[0];
            end
        endcase
    endtask

    // shifts the low n bits of bits, MSB first, checking the serial output
    task automatic send_bits(input logic [15:0] bits, input int n);
        logic prev_msb;
        string tag;
        tag = m_fall ? "R11" : "R10";
        ser_cs_n = 1'b0;
        tick(PH);
        for (int k = 0; k < n; k++) begin
            ser_din = bits[n-1-k];
            tick(PH);
            prev_msb = m_sr[11];
            m_sr = {m_sr[10:0], bits[n-1-k]};
            ser_clk = 1'b1;
            tick(PH);
            chk({tag, " high phase"}, 32'(ser_dout), 32'(m_fall ? prev_msb : m_sr[11]));
            ser_clk = 1'b0;
            tick(PH);
            chk({tag, " low phase"}, 32'(ser_dout), 32'(m_sr[11]));
        end
        ser_cs_n = 1'b1;
        tick(2*PH);
        if (n == 12) apply_word(bits[11:0]);
    endtask

    task automatic send_word(input logic [11:0] w, input string tag);
        send_bits({4'h0, w}, 12);
        chk(tag, dac_word, model_dacs());
    endtask

    task automatic pulse_update();
        upd_all_n = 1'b0;
        tick(PH);
        upd_all_n = 1'b1;
        tick(PH);
        if (!m_clr) for (int i = 0; i < 4; i++) m_dac[i] = m_inp[i];
        chk("R8", dac_word, model_dacs());
    endtask

    task automatic pulse_clear();
        clr_all_n = 1'b0;
        m_clr = 1'b1;
        for (int i = 0; i < 4; i++) begin m_inp[i] = '0; m_dac[i] = '0; end
        tick(PH);
        chk("R9", dac_word, 32'h0);
        clr_all_n = 1'b1;
        m_clr = 1'b0;
        tick(PH);
    endtask

    initial begin
        void'($urandom(32'h1d5c_a7e3));
        for (int i = 0; i < 4; i++) begin m_inp[i] = '0; m_dac[i] = '0; end
        m_fall = 1'b0;
        m_sr   = '0;
        m_clr  = 1'b0;

        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R1 dac", dac_word, 32'h0);
        chk("R1 dout", 32'(ser_dout), 32'h0);

        // directed
        send_word(12'b10_00_1010_0101, "R2 R3");
        send_word(12'b11_10_1111_0000, "R5");
        send_word(12'b01_01_0011_1100, "R4");
        send_word(12'b00_00_0111_0111, "R3 R12");
        pulse_update();

        // malformed frames: 11 and 13 bits, then read back the input bank
        send_bits(16'h07FF, 11);
        chk("R7 short", dac_word, model_dacs());
        send_bits(16'h1F5A, 13);
        chk("R7 long", dac_word, model_dacs());
        send_word(12'b01_10_0110_1001, "R7 R5 readback");

        // switch to falling-edge output
        send_word(12'b00_11_0000_0001, "R6");
        send_word(12'b11_01_1110_0111, "R4 R11");

        // command under clear, with update also held low
        clr_all_n = 1'b0;
        upd_all_n = 1'b0;
        m_clr = 1'b1;
        for (int i = 0; i < 4; i++) begin m_inp[i] = '0; m_dac[i] = '0; end
        send_bits({4'h0, 12'b10_11_1000_0000}, 12);
        chk("R9 during", dac_word, 32'h0);
        clr_all_n = 1'b1;
        upd_all_n = 1'b1;
        m_clr = 1'b0;
        tick(PH);
        chk("R9 after", dac_word, 32'h0);
        send_word(12'b00_10_0000_0000, "R9 readback");
        send_word(12'b00_01_0101_0101, "R11 R4");

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [11:0] w;
            int r;
            w = 12'($urandom);
            r = int'($urandom % 16);
            if (r == 0) begin
                int n;
                n = 8 + int'($urandom % 8);
                if (n == 12) n = 13;
                send_bits(16'($urandom), n);
                chk("R7 random", dac_word, model_dacs());
            end else begin
                send_word(w, op_tag(w));
            end
            if (($urandom % 6) == 0)  pulse_update();
            if (($urandom % 15) == 0) pulse_clear();
        end

        send_word(12'b00_11_0000_0000, "R6 rising");
        send_word(12'b10_01_1100_0011, "R10 R4");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule